// File: doc/BRIEF.md
# MMC Command and Response Engine

This block sends one 48-bit command frame on the card's CMD line and captures the card's reply. Software pushes the command one byte at a time through a valid/ready load port: first the index byte, then the four argument bytes, most significant byte first. It picks three response options, then raises `cmd_go`. The engine builds the frame, which is a start bit, a transmission bit, the index, the argument, a CRC7 and an end bit. It shifts the frame out one bit per clock. It then waits for the card's start bit and collects a 48-bit or 136-bit reply into a byte store. Software drains that store through a valid/ready read port.

The block clock `clk` is the card clock inverted. A rising edge of `clk` is therefore a falling edge of the card clock, so the CMD line changes on the card's falling edge. Three status flags report the reply:
- `eor_flag` marks the end of the reply.
- `fmt_ok` reports that the end bit was valid.
- `crc_ok` reports that the CRC matched.

There is no timeout inside the block. A card has at most 64 card clocks to begin its reply. If the reply never comes, software holds `ctl_reset` to return the engine to idle.

Load port rules: a byte transfers on a rising edge where `cmd_wr_valid` and `cmd_wr_ready` are both high. `cmd_wr_ready` is low when five bytes are held or a transfer is in progress. Read port rules: `rsp_rd_data` is held while `rsp_rd_valid` is high and `rsp_rd_ready` is low. It advances on a rising edge where both are high.

Top module: `mmc_cmd_engine`

## Requirements
- R1: Byte 0 written on the load port supplies the 6-bit index (its bits 5:0 are used). Bytes 1 to 4 are the argument, most significant byte first. `cmd_wr_ready` is low once five bytes are held and while `cmd_busy` is high.
- R2: A rising edge of `cmd_go` seen while idle launches the transfer. Starting in the cycle after that edge, one frame bit per cycle appears on `cmd_out`, most significant bit first: 0, 1, index[5:0], argument[31:0], CRC7, 1. `cmd_oe` is high only during those 48 cycles. `cmd_out` is 1 whenever `cmd_oe` is low.
- R3: The frame CRC7 is the remainder of the first 40 frame bits multiplied by x^7, divided by x^7+x^3+1.
- R4: A launch clears `eor_flag`, `fmt_ok` and `crc_ok`, and empties the response store. It also returns the load write pointer to zero.
- R5: With `resp_en`=0, the engine does not wait for a reply. `cmd_busy` falls right after the end bit, and `eor_flag` stays 0.
- R6: With `resp_en`=1, the engine waits for the first 0 on `cmd_in` and takes that bit as the reply start bit. It then captures 48 bits in total (`resp_long`=0) or 136 bits (`resp_long`=1), one per cycle. Each group of 8 bits becomes one byte, with the first bit in bit 7, giving 6 or 17 bytes.
- R7: `fmt_ok` is set to the value of the last captured bit, which is the end bit and must be 1.
- R8: `crc_ok` compares a CRC7 over part of the reply with the 7 bits just before the end bit, using bit positions counted from the last bit as position 0:
  - For a short reply, the CRC covers positions 47..8.
  - For a long reply, it covers positions 127..8 only, so the start, transmission and reserved bits are excluded.
  - With `crc_skip`=1, `crc_ok` is set to 1.
- R9: `eor_flag` is set in the cycle after the last reply bit is sampled, at the same time as `cmd_busy` falls. It holds until the next launch.
- R10: Holding `tx_ptr_clr` high for a cycle returns the load write pointer to zero. The next byte written becomes the index byte.
- R11: Holding `rx_ptr_clr` high for a cycle returns the read pointer to zero. The next byte read is reply byte 0 again.
- R12: Holding `ctl_reset` high for a cycle returns the engine to idle from any state. `cmd_out` goes to 1 and `cmd_oe` to 0. The status flags are left unchanged.
- R13: `rsp_rd_valid` is high while unread reply bytes remain. `rsp_rd_data` is stable while valid is high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, card clock inverted |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_valid | input | 1 | Load byte valid |
| cmd_wr_ready | output | 1 | Load byte accepted |
| cmd_wr_data | input | 8 | Load byte |
| resp_en | input | 1 | A reply is expected |
| resp_long | input | 1 | Reply is 136 bits (else 48) |
| crc_skip | input | 1 | Skip the reply CRC check |
| cmd_go | input | 1 | Launch on rising edge |
| tx_ptr_clr | input | 1 | Reset the load write pointer |
| rx_ptr_clr | input | 1 | Reset the read pointer |
| ctl_reset | input | 1 | Return the engine to idle |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line sampled value |
| cmd_busy | output | 1 | Transfer in progress |
| eor_flag | output | 1 | End of reply |
| fmt_ok | output | 1 | Reply end bit valid |
| crc_ok | output | 1 | Reply CRC correct |
| rsp_rd_valid | output | 1 | Reply byte available |
| rsp_rd_ready | input | 1 | Reply byte taken |
| rsp_rd_data | output | 8 | Reply byte |

## Verification
The frame is checked for every one of the 64 index values, each with a distinct argument. A walking one across all 32 argument bits follows, so that a wrong field order or a CRC tap error shows at one precise bit. Replies are driven in both lengths:
- Correct replies confirm the capture and the byte order.
- A flipped CRC bit and a bad end bit tell `crc_ok` apart from `fmt_ok`.
- A long reply with changed reserved bits shows that the excluded range is really excluded.
- A bad CRC with `crc_skip` set shows that the skip option works.

Pointer resets, the controller reset during a reply that never comes, and read back-pressure are each exercised on their own.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_RECV} eng_state_t;

  // One serial step of CRC7 with generator x^7 + x^3 + 1.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction
endpackage

// File: rtl/mmc_tx_fifo.sv
module mmc_tx_fifo #(
  parameter int W     = 8,
  parameter int IDX_W = 6,
  parameter int ARG_N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               block,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [W-1:0]       wr_data,
  output logic [IDX_W-1:0]   idx,
  output logic [ARG_N*W-1:0] arg
);
  localparam int SLOTS = ARG_N + 1;
  localparam int PW    = $clog2(SLOTS + 1);

  logic [PW-1:0] wptr;

  assign wr_ready = (wptr < PW'(SLOTS)) && !block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      idx  <= '0;
      arg  <= '0;
    end else if (clr) begin
      wptr <= '0;
    end else if (wr_valid && wr_ready) begin
      if (wptr == '0) idx <= wr_data[IDX_W-1:0];
      else arg[(SLOTS - 1 - int'(wptr))*W +: W] <= wr_data;
      wptr <= wptr + 1'b1;
    end
  end
endmodule

// File: rtl/mmc_rx_store.sv
module mmc_rx_store #(
  parameter int W     = 8,
  parameter int DEPTH = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         rewind,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wcnt, rptr;

  assign rd_valid = rptr < wcnt;
  assign rd_data  = (rptr < AW'(DEPTH)) ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (push && !flush && wcnt < AW'(DEPTH)) mem[wcnt] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      rptr <= '0;
    end else if (flush) begin
      wcnt <= '0;
      rptr <= '0;
    end else begin
      if (push && wcnt < AW'(DEPTH)) wcnt <= wcnt + 1'b1;
      if (rewind) rptr <= '0;
      else if (rd_valid && rd_ready) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/mmc_crc7_acc.sv
module mmc_crc7_acc import mmc_cmd_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic       bit_in,
  output logic [6:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (en)    crc <= crc7_step(crc, bit_in);
  end
endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine import mmc_cmd_pkg::*; #(
  parameter int ARG_BYTES  = 4,
  parameter int BYTE_W     = 8,
  parameter int IDX_W      = 6,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_valid,
  output logic              cmd_wr_ready,
  input  logic [BYTE_W-1:0] cmd_wr_data,
  input  logic              resp_en,
  input  logic              resp_long,
  input  logic              crc_skip,
  input  logic              cmd_go,
  input  logic              tx_ptr_clr,
  input  logic              rx_ptr_clr,
  input  logic              ctl_reset,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in,
  output logic              cmd_busy,
  output logic              eor_flag,
  output logic              fmt_ok,
  output logic              crc_ok,
  output logic              rsp_rd_valid,
  input  logic              rsp_rd_ready,
  output logic [BYTE_W-1:0] rsp_rd_data
);
  localparam int ARG_W    = ARG_BYTES * BYTE_W;
  localparam int HEAD_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W  = HEAD_W + 8;
  localparam int RX_BYTES = LONG_BITS / BYTE_W;
  localparam int CNT_W    = $clog2(LONG_BITS + 1);
  localparam int BIX_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] SEND_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] S_LAST    = CNT_W'(SHORT_BITS - 1);
  localparam logic [CNT_W-1:0] L_LAST    = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] S_CRC_HI  = CNT_W'(SHORT_BITS - 9);
  localparam logic [CNT_W-1:0] L_CRC_HI  = CNT_W'(LONG_BITS - 9);
  localparam logic [CNT_W-1:0] L_CRC_LO  = CNT_W'(8);

  eng_state_t         state;
  logic               go_q, launch, take, push;
  logic               ren_q, long_q, skip_q;
  logic [CNT_W-1:0]   cnt, last_k, crc_lo, crc_hi;
  logic               in_crc, in_fld;
  logic [FRAME_W-1:0] shreg, frame;
  logic [HEAD_W-1:0]  head;
  logic [6:0]         tx_crc, rx_crc, fld_sh;
  logic [BYTE_W-1:0]  byte_sh;
  logic [IDX_W-1:0]   idx;
  logic [ARG_W-1:0]   arg;

  mmc_tx_fifo #(.W(BYTE_W), .IDX_W(IDX_W), .ARG_N(ARG_BYTES)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_ptr_clr | launch), .block(cmd_busy),
    .wr_valid(cmd_wr_valid), .wr_ready(cmd_wr_ready), .wr_data(cmd_wr_data),
    .idx(idx), .arg(arg));

  mmc_rx_store #(.W(BYTE_W), .DEPTH(RX_BYTES)) u_rxs (
    .clk(clk), .rst_n(rst_n), .flush(launch), .rewind(rx_ptr_clr),
    .push(push), .push_data({byte_sh[BYTE_W-2:0], cmd_in}),
    .rd_valid(rsp_rd_valid), .rd_ready(rsp_rd_ready), .rd_data(rsp_rd_data));

  mmc_crc7_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .en(take && in_crc),
    .bit_in(cmd_in), .crc(rx_crc));

  // Outgoing frame with its CRC7 over the header bits.
  always_comb begin
    head   = {2'b01, idx, arg};
    tx_crc = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) tx_crc = crc7_step(tx_crc, head[i]);
    frame  = {head, tx_crc, 1'b1};
  end

  assign launch   = cmd_go && !go_q && (state == ST_IDLE) && !ctl_reset;
  assign cmd_busy = (state != ST_IDLE);
  assign cmd_oe   = (state == ST_SEND);
  assign cmd_out  = cmd_oe ? shreg[FRAME_W-1] : 1'b1;

  // Reply bit bookkeeping: which received bits feed the CRC, which are the field.
  assign take   = ((state == ST_WAIT) && !cmd_in) || (state == ST_RECV);
  assign last_k = long_q ? L_LAST : S_LAST;
  assign crc_hi = long_q ? L_CRC_HI : S_CRC_HI;
  assign crc_lo = long_q ? L_CRC_LO : '0;
  assign in_crc = (cnt >= crc_lo) && (cnt <= crc_hi);
  assign in_fld = (cnt > crc_hi) && (cnt < last_k);
  assign push   = take && (cnt[BIX_W-1:0] == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      go_q     <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      ren_q    <= 1'b0;
      long_q   <= 1'b0;
      skip_q   <= 1'b0;
      byte_sh  <= '0;
      fld_sh   <= '0;
      eor_flag <= 1'b0;
      fmt_ok   <= 1'b0;
      crc_ok   <= 1'b0;
    end else begin
      go_q <= cmd_go;
      if (ctl_reset) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (launch) begin
            shreg    <= frame;
            cnt      <= '0;
            ren_q    <= resp_en;
            long_q   <= resp_long;
            skip_q   <= crc_skip;
            eor_flag <= 1'b0;
            fmt_ok   <= 1'b0;
            crc_ok   <= 1'b0;
            state    <= ST_SEND;
          end
          ST_SEND: begin
            shreg <= shreg << 1;
            if (cnt == SEND_LAST) begin
              cnt   <= '0;
              state <= ren_q ? ST_WAIT : ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: if (take) begin
            byte_sh <= {byte_sh[BYTE_W-2:0], cmd_in};
            if (in_fld) fld_sh <= {fld_sh[5:0], cmd_in};
            if (cnt == last_k) begin
              state    <= ST_IDLE;
              eor_flag <= 1'b1;
              fmt_ok   <= cmd_in;
              crc_ok   <= skip_q || (rx_crc == fld_sh);
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_RECV;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mmc_cmd_engine_chk.sv
module mmc_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr_ready,
  input logic cmd_go,
  input logic rx_ptr_clr,
  input logic ctl_reset,
  input logic cmd_out,
  input logic cmd_oe,
  input logic cmd_busy,
  input logic eor_flag,
  input logic fmt_ok,
  input logic crc_ok,
  input logic rsp_rd_valid,
  input logic rsp_rd_ready,
  input logic [7:0] rsp_rd_data
);
  // R1
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !cmd_wr_ready);

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);

  // R2
  drive_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_busy);

  // R4
  launch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> (!eor_flag && !fmt_ok && !crc_ok && !rsp_rd_valid));

  // R9
  eor_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eor_flag) |-> !cmd_busy);

  // R12
  reset_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> !cmd_busy);

  // R13
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rd_valid && !rsp_rd_ready && !rx_ptr_clr && !cmd_go) |=>
      (rsp_rd_valid && $stable(rsp_rd_data)));
endmodule

bind mmc_cmd_engine mmc_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr_ready(cmd_wr_ready), .cmd_go(cmd_go),
  .rx_ptr_clr(rx_ptr_clr), .ctl_reset(ctl_reset), .cmd_out(cmd_out),
  .cmd_oe(cmd_oe), .cmd_busy(cmd_busy), .eor_flag(eor_flag), .fmt_ok(fmt_ok),
  .crc_ok(crc_ok), .rsp_rd_valid(rsp_rd_valid), .rsp_rd_ready(rsp_rd_ready),
  .rsp_rd_data(rsp_rd_data));

// File: tb/mmc_cmd_engine_tb.sv
module mmc_cmd_engine_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_wr_valid = 1'b0, cmd_wr_ready;
  logic [7:0] cmd_wr_data = '0;
  logic resp_en = 1'b0, resp_long = 1'b0, crc_skip = 1'b0, cmd_go = 1'b0;
  logic tx_ptr_clr = 1'b0, rx_ptr_clr = 1'b0, ctl_reset = 1'b0;
  logic cmd_out, cmd_oe, cmd_in = 1'b1, cmd_busy, eor_flag, fmt_ok, crc_ok;
  logic rsp_rd_valid, rsp_rd_ready = 1'b0;
  logic [7:0] rsp_rd_data;

  int errs = 0, checks = 0;

  mmc_cmd_engine u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Long division of the selected bits times x^7 by x^7+x^3+1.
  function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int lo);
    logic [7:0] r = '0;
    for (int p = hi; p >= lo; p--) begin
      r = {r[6:0], v[p]};
      if (r[7]) r ^= 8'h89;
    end
    for (int i = 0; i < 7; i++) begin
      r = {r[6:0], 1'b0};
      if (r[7]) r ^= 8'h89;
    end
    return r[6:0];
  endfunction

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    cmd_wr_valid = 1'b1;
    cmd_wr_data  = b;
    while (!cmd_wr_ready) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] ib, input logic [31:0] arg);
    push_byte(ib);
    for (int i = 3; i >= 0; i--) push_byte(arg[i*8 +: 8]);
    @(negedge clk) cmd_wr_valid = 1'b0;
  endtask

  task automatic launch_collect(input logic [5:0] idx, input logic [31:0] arg,
                                input bit ren, input bit rl, input bit sk);
    logic [47:0] got, exp;
    logic [39:0] head;
    int oe_bad = 0;
    head = {2'b01, idx, arg};
    exp  = {head, ref_crc({96'b0, head}, 39, 0), 1'b1};
    @(negedge clk);
    resp_en = ren; resp_long = rl; crc_skip = sk; cmd_go = 1'b1;
    @(negedge clk) cmd_go = 1'b0;
    // R4 flags and store cleared by the launch
    chk("R4 flags after launch", {eor_flag, fmt_ok, crc_ok, rsp_rd_valid}, 4'b0000);
    for (int i = 47; i >= 0; i--) begin
      if (i != 47) @(negedge clk);
      got[i] = cmd_out;
      if (!cmd_oe) oe_bad++;
      if (i == 37) chk("R1 load blocked while busy", cmd_wr_ready, 1'b0);
    end
    chk("R2 frame header", got[47:8], exp[47:8]);
    chk("R3 frame crc7", got[7:0], exp[7:0]);
    chk("R2 drive enable during frame", oe_bad, 0);
    @(negedge clk);
    // R5 no wait without a reply; busy stays in wait otherwise
    chk("R5 busy after frame", cmd_busy, ren);
    chk("R2 line released", {cmd_oe, cmd_out}, 2'b01);
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input bit ren, input bit rl, input bit sk);
    load({2'b11, idx}, arg);
    launch_collect(idx, arg, ren, rl, sk);
  endtask

  task automatic respond(input logic [135:0] v, input int n);
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) @(negedge clk) cmd_in = v[n-1-k];
    @(negedge clk) cmd_in = 1'b1;
  endtask

  task automatic read_bytes(input logic [135:0] v, input int n, input int from, input int cnt);
    @(negedge clk) rsp_rd_ready = 1'b1;
    for (int j = from; j < from + cnt; j++) begin
      if (j != from) @(negedge clk);
      // R6 byte order, first bit in bit 7 of byte 0
      chk("R6 reply byte", {rsp_rd_valid, rsp_rd_data}, {1'b1, v[n-1-8*j -: 8]});
    end
    @(negedge clk) rsp_rd_ready = 1'b0;
    if (from + cnt == n / 8) chk("R13 store drained", rsp_rd_valid, 1'b0);
  endtask

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] pl);
    logic [135:0] v = '0;
    v[47:40] = {2'b00, idx};
    v[39:8]  = pl;
    v[7:1]   = ref_crc(v, 47, 8);
    v[0]     = 1'b1;
    return v;
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] pl, input logic [5:0] rsv);
    logic [135:0] v = '0;
    v[135:128] = {2'b00, rsv};
    v[127:8]   = pl;
    v[7:1]     = ref_crc(v, 127, 8);
    v[0]       = 1'b1;
    return v;
  endfunction

  task automatic flags(input string tag, input logic [2:0] exp);
    chk(tag, {eor_flag, fmt_ok, crc_ok, cmd_busy}, {exp, 1'b0});
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [135:0] v;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset line", {cmd_out, cmd_oe, cmd_busy}, 3'b100);
    chk("R1 reset ready", cmd_wr_ready, 1'b1);
    chk("R9 reset flags", {eor_flag, fmt_ok, crc_ok, rsp_rd_valid}, 4'b0);

    // R2 R3 R5: every index, distinct arguments, no reply
    for (int i = 0; i < 64; i++) begin
      run_cmd(6'(i), 32'h9E3779B9 * 32'(i + 1), 1'b0, 1'b0, 1'b0);
      chk("R5 no eor without reply", eor_flag, 1'b0);
    end
    // R3 walking one across the argument
    for (int b = 0; b < 32; b++) run_cmd(6'd17, 32'h1 << b, 1'b0, 1'b0, 1'b0);

    // R6 R7 R8 R9 short reply, correct
    v = mk_short(6'd17, 32'hC0FFEE42);
    run_cmd(6'd17, 32'h0000_1234, 1'b1, 1'b0, 1'b0);
    respond(v, 48);
    flags("R9 R7 R8 short good", 3'b111);
    // R13 back-pressure hold
    held = rsp_rd_data;
    repeat (5) @(negedge clk);
    chk("R13 hold while not ready", {rsp_rd_valid, rsp_rd_data}, {1'b1, held});
    read_bytes(v, 48, 0, 6);

    // R8 short, flipped CRC bit
    v = mk_short(6'd3, 32'h5A5A0F0F);
    v[4] = ~v[4];
    run_cmd(6'd3, 32'h0, 1'b1, 1'b0, 1'b0);
    respond(v, 48);
    flags("R8 short bad crc", 3'b110);

    // R7 short, bad end bit
    v = mk_short(6'd3, 32'h5A5A0F0F);
    v[0] = 1'b0;
    run_cmd(6'd3, 32'h0, 1'b1, 1'b0, 1'b0);
    respond(v, 48);
    flags("R7 short bad end bit", 3'b101);

    // R8 skip forces crc_ok
    v = mk_short(6'd9, 32'h11223344);
    v[1] = ~v[1];
    run_cmd(6'd9, 32'h0, 1'b1, 1'b0, 1'b1);
    respond(v, 48);
    flags("R8 crc skip", 3'b111);

    // R6 R8 long, correct, then R11 rewind
    v = mk_long(120'hF00D_1234_5678_9ABC_DEF0_0FED_CBA9_87, 6'h3F);
    run_cmd(6'd2, 32'h0, 1'b1, 1'b1, 1'b0);
    respond(v, 136);
    flags("R8 long good", 3'b111);
    read_bytes(v, 136, 0, 3);
    pulse(rx_ptr_clr);
    // R11 reading restarts at byte 0
    read_bytes(v, 136, 0, 17);

    // R8 long: reserved bits outside the checked range
    v = mk_long(120'h0123_4567_89AB_CDEF_0011_2233_4455_66, 6'h3F);
    v[133:128] = 6'h15;
    run_cmd(6'd10, 32'h0, 1'b1, 1'b1, 1'b0);
    respond(v, 136);
    flags("R8 long reserved excluded", 3'b111);

    // R8 long, flipped payload bit
    v = mk_long(120'h0123_4567_89AB_CDEF_0011_2233_4455_66, 6'h3F);
    v[60] = ~v[60];
    run_cmd(6'd10, 32'h0, 1'b1, 1'b1, 1'b0);
    respond(v, 136);
    flags("R8 long bad crc", 3'b110);

    // R1 full after five bytes, R10 pointer reset
    load(8'hAA, 32'hDEADBEEF);
    chk("R1 ready low when full", cmd_wr_ready, 1'b0);
    pulse(tx_ptr_clr);
    chk("R10 ready after pointer reset", cmd_wr_ready, 1'b1);
    push_byte(8'h55);
    push_byte(8'h66);
    @(negedge clk) cmd_wr_valid = 1'b0;
    pulse(tx_ptr_clr);
    run_cmd(6'd41, 32'h01234567, 1'b0, 1'b0, 1'b0);

    // R12 missing card: stuck waiting, then controller reset
    run_cmd(6'd1, 32'h0, 1'b1, 1'b0, 1'b0);
    repeat (70) @(negedge clk);
    chk("R12 still waiting", cmd_busy, 1'b1);
    pulse(ctl_reset);
    chk("R12 idle after reset", {cmd_busy, cmd_oe, cmd_out}, 3'b001);
    chk("R12 flags unchanged", {eor_flag, fmt_ok, crc_ok}, 3'b000);
    v = mk_short(6'd1, 32'h87654321);
    run_cmd(6'd1, 32'h0, 1'b1, 1'b0, 1'b0);
    respond(v, 48);
    flags("R12 works after reset", 3'b111);
    read_bytes(v, 48, 0, 6);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule